// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address by reading page-table entries out of memory one level at a time. A request carries the virtual address, a three-bit translation-scheme selector, the page number of the root table, and the privilege state that decides whether translation applies at all. The walker then issues one entry read at a time on a simple memory port and waits for the read-valid reply before it decides whether to descend or stop.

Three radix schemes share a single state machine: a two-level scheme with 10-bit indices and 4-byte entries, and three-level and four-level schemes with 9-bit indices and 8-byte entries. A leaf found above the last level maps a superpage: the low virtual page bits that the remaining levels would have indexed are merged into the leaf's page number. A bare scheme, or machine-level effective privilege, returns the address unchanged with no memory traffic.

A result leaves as a one-cycle response carrying the physical address or a fault flag. Permission checks, translation caching and accessed/dirty bookkeeping are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: Scheme code 1 walks 2 levels with 10-bit indices and 4-byte entries, using only bits 31:0 of the read data; code 2 walks 3 levels and code 3 walks 4 levels, both with 9-bit indices and 8-byte entries using all 64 data bits.
- R2: The first table base is the root page number shifted left by 12; each entry address is the current base plus index times entry size, where the index is the index-width field of the virtual address starting at bit 12 plus a level shift that begins at (levels-1) times the index width and falls by one index width per level.
- R3: An entry with bit 0 (valid) set and bits 1, 2 and 3 all clear points to the next table, whose base is the entry shifted right by 10 then left by 12.
- R4: Any other valid entry is a leaf: the physical address is ((entry>>10) OR (virtual page number bits below the current level shift)) shifted left by 12, with virtual address bits 11:0 appended unchanged.
- R5: If the last level yields a table pointer, the response flags a fault; every fault response carries a physical address of zero.
- R6: An entry with bit 0 clear ends the walk at once with a fault and no further reads.
- R7: With scheme code 0, or with effective privilege equal to 3, the response arrives in the cycle after acceptance with the virtual address returned unchanged, no fault and no memory read.
- R8: The effective privilege is the current-privilege input when the modify-privilege input is 0, and the previous-privilege input when it is 1.
- R9: Scheme codes 4 to 7 under non-bypassed privilege give a fault response in the cycle after acceptance with no memory read.
- R10: At most one entry read is outstanding: a read request is a one-cycle pulse and no new one is raised before the reply to the last.
- R11: The request-ready output is high at idle and after reset, low from acceptance through the response cycle; requests presented while busy have no effect; the response valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| req_mode | input | 3 | Scheme: 0 bare, 1 two-level, 2 three-level, 3 four-level, 4-7 unsupported |
| req_root | input | PPN_W | Root table page number |
| req_cur_priv | input | 2 | Current privilege level (3 = machine) |
| req_mprv | input | 1 | Use the previous-privilege field for data accesses |
| req_prev_priv | input | 2 | Previous privilege level |
| mem_req_valid | output | 1 | Entry read request, one-cycle pulse |
| mem_req_addr | output | ADDR_W | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Entry read data |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_paddr | output | ADDR_W | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |

## Verification
The overlap that matters is a memory reply arriving in the very cycle a new translation request is waiting at the request port. The bench provokes it by keeping a distracting request valid, with another address and scheme, for the whole of a walk whose entry replies come back after random delays. It is judged by the response still matching the model's walk of the first address, by the count of entry reads equalling the model's count, and by the ready output only returning high after the response pulse.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int PPN_LSB    = 10;
    localparam int SHIFT_W    = 6;

    localparam logic [2:0] MODE_BARE  = 3'd0;
    localparam logic [2:0] MODE_TWO   = 3'd1;
    localparam logic [2:0] MODE_THREE = 3'd2;
    localparam logic [2:0] MODE_FOUR  = 3'd3;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef struct packed {
        logic [2:0] levels;
        logic [3:0] idx_w;
        logic       pte8;
        logic       known;
    } geom_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } wstate_e;

    function automatic geom_t mode_geom(input logic [2:0] m);
        geom_t g;
        g = '0;
        case (m)
            MODE_TWO:   g = '{levels: 3'd2, idx_w: 4'd10, pte8: 1'b0, known: 1'b1};
            MODE_THREE: g = '{levels: 3'd3, idx_w: 4'd9,  pte8: 1'b1, known: 1'b1};
            MODE_FOUR:  g = '{levels: 3'd4, idx_w: 4'd9,  pte8: 1'b1, known: 1'b1};
            default:    g = '0;
        endcase
        return g;
    endfunction

    function automatic logic [SHIFT_W-1:0] first_shift(input geom_t g);
        logic [SHIFT_W-1:0] lv;
        logic [SHIFT_W-1:0] w;
        lv = {{(SHIFT_W-3){1'b0}}, g.levels} - 6'd1;
        w  = {{(SHIFT_W-4){1'b0}}, g.idx_w};
        return lv * w;
    endfunction

endpackage

// File: rtl/pt_walker_mode_dec.sv
module pt_walker_mode_dec
    import pt_walker_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] cur_priv,
    input  logic       mprv,
    input  logic [1:0] prev_priv,
    output geom_t      geom,
    output logic       bypass,
    output logic       unsupported
);
    logic [1:0] eff_priv;

    always_comb begin
        eff_priv    = mprv ? prev_priv : cur_priv;
        geom        = mode_geom(mode);
        bypass      = (mode == MODE_BARE) || (eff_priv == PRIV_MACHINE);
        unsupported = !bypass && !geom.known;
    end
endmodule

// File: rtl/pt_walker_addr_gen.sv
module pt_walker_addr_gen
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]  vaddr,
    input  logic [ADDR_W-1:0]  base,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [3:0]         idx_w,
    input  logic               pte8,
    output logic [ADDR_W-1:0]  pte_addr
);
    logic [ADDR_W-1:0] idx_mask;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        idx_mask = (ADDR_W'(1) << idx_w) - ADDR_W'(1);
        idx      = (vaddr >> (PAGE_SHIFT + int'(shift))) & idx_mask;
        pte_addr = base + (pte8 ? (idx << 3) : (idx << 2));
    end
endmodule

// File: rtl/pt_walker_pte_eval.sv
module pt_walker_pte_eval
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]  raw,
    input  logic               pte8,
    input  logic [ADDR_W-1:0]  vaddr,
    input  logic [SHIFT_W-1:0] shift,
    output logic               valid,
    output logic               is_table,
    output logic [ADDR_W-1:0]  next_base,
    output logic [ADDR_W-1:0]  leaf_paddr
);
    localparam logic [ADDR_W-1:0] OFFSET_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

    logic [DATA_W-1:0] pte;
    logic [ADDR_W-1:0] ppn;
    logic [ADDR_W-1:0] vpn;
    logic [ADDR_W-1:0] sp_mask;

    always_comb begin
        pte        = pte8 ? raw : DATA_W'(raw[31:0]);
        ppn        = ADDR_W'(pte >> PPN_LSB);
        valid      = pte[0];
        is_table   = pte[0] && (pte[3:1] == 3'b000);
        next_base  = ppn << PAGE_SHIFT;
        vpn        = vaddr >> PAGE_SHIFT;
        sp_mask    = (ADDR_W'(1) << shift) - ADDR_W'(1);
        leaf_paddr = ((ppn | (vpn & sp_mask)) << PAGE_SHIFT) | (vaddr & OFFSET_MASK);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int PPN_W  = 44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [2:0]        req_mode,
    input  logic [PPN_W-1:0]  req_root,
    input  logic [1:0]        req_cur_priv,
    input  logic              req_mprv,
    input  logic [1:0]        req_prev_priv,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault
);
    wstate_e            state;
    logic [ADDR_W-1:0]  va_q;
    logic [ADDR_W-1:0]  base_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [2:0]         lvl_q;
    logic [3:0]         idx_w_q;
    logic               pte8_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic               fault_q;

    geom_t             geom;
    logic              bypass;
    logic              unsupported;
    logic [ADDR_W-1:0] pte_addr;
    logic              pte_valid;
    logic              pte_table;
    logic [ADDR_W-1:0] next_base;
    logic [ADDR_W-1:0] leaf_paddr;
    logic              accept;

    pt_walker_mode_dec u_dec (
        .mode        (req_mode),
        .cur_priv    (req_cur_priv),
        .mprv        (req_mprv),
        .prev_priv   (req_prev_priv),
        .geom        (geom),
        .bypass      (bypass),
        .unsupported (unsupported)
    );

    pt_walker_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .vaddr    (va_q),
        .base     (base_q),
        .shift    (shift_q),
        .idx_w    (idx_w_q),
        .pte8     (pte8_q),
        .pte_addr (pte_addr)
    );

    pt_walker_pte_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eval (
        .raw        (mem_rsp_data),
        .pte8       (pte8_q),
        .vaddr      (va_q),
        .shift      (shift_q),
        .valid      (pte_valid),
        .is_table   (pte_table),
        .next_base  (next_base),
        .leaf_paddr (leaf_paddr)
    );

    assign accept        = (state == ST_IDLE) && req_valid;
    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign mem_req_addr  = pte_addr;
    assign rsp_valid     = (state == ST_RESP);
    assign rsp_paddr     = paddr_q;
    assign rsp_fault     = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            shift_q <= '0;
            lvl_q   <= '0;
            idx_w_q <= '0;
            pte8_q  <= 1'b0;
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        va_q    <= req_vaddr;
                        base_q  <= ADDR_W'(req_root) << PAGE_SHIFT;
                        shift_q <= first_shift(geom);
                        lvl_q   <= geom.levels - 3'd1;
                        idx_w_q <= geom.idx_w;
                        pte8_q  <= geom.pte8;
                        if (bypass) begin
                            paddr_q <= req_vaddr;
                            fault_q <= 1'b0;
                            state   <= ST_RESP;
                        end else if (unsupported) begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end else begin
                            paddr_q <= '0;
                            fault_q <= 1'b0;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!pte_valid) begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end else if (pte_table) begin
                            if (lvl_q == 3'd0) begin
                                paddr_q <= '0;
                                fault_q <= 1'b1;
                                state   <= ST_RESP;
                            end else begin
                                base_q  <= next_base;
                                shift_q <= shift_q - {{(SHIFT_W-4){1'b0}}, idx_w_q};
                                lvl_q   <= lvl_q - 3'd1;
                                state   <= ST_ISSUE;
                            end
                        end else begin
                            paddr_q <= leaf_paddr;
                            fault_q <= 1'b0;
                            state   <= ST_RESP;
                        end
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Tracks a read that has been requested and not yet answered.
    logic rd_pending;
    always_ff @(posedge clk) begin
        if (rst) rd_pending <= 1'b0;
        else if (mem_req_valid) rd_pending <= 1'b1;
        else if (mem_rsp_valid) rd_pending <= 1'b0;
    end

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_pending);

    assert_read_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready &&
         ((req_mode == 3'd0) || ((req_mprv ? req_prev_priv : req_cur_priv) == 2'b11)))
        |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)));

    assert_unsupported_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_mode >= 3'd4) &&
         ((req_mprv ? req_prev_priv : req_cur_priv) != 2'b11))
        |=> (rsp_valid && rsp_fault));

    assert_invalid_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mem_rsp_valid && !mem_rsp_data[0]) |=> (rsp_valid && rsp_fault));

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_vaddr;
    logic [2:0]  req_mode;
    logic [43:0] req_root;
    logic [1:0]  req_cur_priv;
    logic        req_mprv;
    logic [1:0]  req_prev_priv;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int cycles = 0;

    logic [63:0] mem [bit [63:0]];

    pt_walker u0 (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
        .req_mode (req_mode), .req_root (req_root), .req_cur_priv (req_cur_priv),
        .req_mprv (req_mprv), .req_prev_priv (req_prev_priv),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11 actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // Memory model: replies 1 to 3 cycles after a read request.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            while (mem_req_valid) begin
                logic [63:0] a;
                a = mem_req_addr;
                reads++;
                repeat ($urandom_range(1, 3)) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = {$urandom, $urandom};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void geo(input logic [2:0] m, output int lv, output int w, output int sz);
        case (m)
            3'd1: begin lv = 2; w = 10; sz = 4; end
            3'd2: begin lv = 3; w = 9;  sz = 8; end
            default: begin lv = 4; w = 9; sz = 8; end
        endcase
    endfunction

    function automatic void ref_walk(input logic [63:0] va, input logic [2:0] mode, input logic [43:0] root,
                                     input logic [1:0] cur, input logic mprv, input logic [1:0] prev,
                                     output logic [63:0] pa, output logic flt, output int nrd);
        int lv, w, sz, sh;
        logic [1:0]  eff;
        logic [63:0] base, idx, a, pte;
        eff = mprv ? prev : cur;
        nrd = 0;
        pa  = 64'd0;
        flt = 1'b1;
        if (mode == 3'd0 || eff == 2'd3) begin
            pa = va; flt = 1'b0; return;
        end
        if (mode >= 3'd4) return;
        geo(mode, lv, w, sz);
        base = {20'd0, root} << 12;
        sh = (lv - 1) * w;
        for (int i = 0; i < lv; i++) begin
            idx = (va >> (12 + sh)) & ((64'd1 << w) - 64'd1);
            a   = base + idx * 64'(sz);
            pte = rd(a);
            if (sz == 4) pte = pte & 64'hFFFF_FFFF;
            nrd++;
            if (!pte[0]) return;
            if (pte[3:1] == 3'b000) begin
                base = (pte >> 10) << 12;
                sh   = sh - w;
            end else begin
                pa  = (((pte >> 10) | ((va >> 12) & ((64'd1 << sh) - 64'd1))) << 12) | (va & 64'hFFF);
                flt = 1'b0;
                return;
            end
        end
    endfunction

    // Writes one path of entries; leaf_lvl >= levels gives an all-pointer path.
    function automatic void build(input logic [63:0] va, input logic [2:0] mode, input logic [43:0] root,
                                  input int leaf_lvl, input int bad_lvl);
        int lv, w, sz, sh;
        logic [63:0] base, idx, a, pte, ppn;
        geo(mode, lv, w, sz);
        base = {20'd0, root} << 12;
        sh = (lv - 1) * w;
        for (int i = 0; i < lv; i++) begin
            idx = (va >> (12 + sh)) & ((64'd1 << w) - 64'd1);
            a   = base + idx * 64'(sz);
            if (i == bad_lvl) begin
                pte = {$urandom, $urandom} & ~64'd1;
                mem[a] = pte;
                return;
            end
            if (i == leaf_lvl) begin
                ppn = {$urandom, $urandom} & ((sz == 4) ? 64'h3F_FFFF : 64'hFFF_FFFF_FFFF);
                pte = (ppn << 10) | (64'($urandom_range(1, 7)) << 1) | 64'd1;
                if (sz == 4) pte = pte | {$urandom, 32'd0};
                mem[a] = pte;
                return;
            end
            ppn = 64'($urandom_range(1, 32'hF_FFFF));
            pte = (ppn << 10) | 64'd1;
            if (sz == 4) pte = pte | {$urandom, 32'd0};
            mem[a] = pte;
            base = ppn << 12;
            sh = sh - w;
        end
    endfunction

    task automatic run(input logic [63:0] va, input logic [2:0] mode, input logic [43:0] root,
                       input logic [1:0] cur, input logic mprv, input logic [1:0] prev,
                       input bit distract, input string tag);
        logic [63:0] epa;
        logic        eflt;
        int          enrd, wait_cyc;
        ref_walk(va, mode, root, cur, mprv, prev, epa, eflt, enrd);
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1; req_vaddr = va; req_mode = mode; req_root = root;
        req_cur_priv = cur; req_mprv = mprv; req_prev_priv = prev;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (distract) begin
            req_vaddr = ~va; req_mode = 3'd2; req_cur_priv = 2'd1; req_mprv = 1'b0;
        end else begin
            req_valid = 1'b0;
        end
        wait_cyc = 0;
        while (!rsp_valid && wait_cyc < 300) begin
            @(negedge clk);
            wait_cyc++;
        end
        req_valid = 1'b0;
        chk(rsp_valid, {"R11 response ", tag}, 64'(rsp_valid), 64'd1);
        chk(rsp_fault == eflt, {"fault ", tag}, 64'(rsp_fault), 64'(eflt));
        chk(rsp_paddr == epa, {"paddr ", tag}, rsp_paddr, epa);
        chk(!req_ready, {"R11 busy at response ", tag}, 64'(req_ready), 64'd0);
        if (enrd == 0)
            chk(wait_cyc == 0, {"R7/R9 latency ", tag}, 64'(wait_cyc), 64'd0);
        @(negedge clk);
        chk(reads == enrd, {"R10 read count ", tag}, 64'(reads), 64'(enrd));
        chk(!rsp_valid && req_ready, {"R11 pulse ", tag}, 64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        logic [63:0] va;
        logic [43:0] root;
        void'($urandom(32'd20250611));
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_mode = '0; req_root = '0;
        req_cur_priv = '0; req_mprv = 1'b0; req_prev_priv = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R11 reset state",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        rst = 1'b0;

        // R7: bare scheme
        run(64'hDEAD_BEEF_0123_4567, 3'd0, 44'h12, 2'd0, 1'b0, 2'd0, 1'b0, "R7 bare");
        // R7: machine privilege bypasses a walking scheme
        run(64'h0000_0040_1234_5FFF, 3'd2, 44'h12, 2'd3, 1'b0, 2'd0, 1'b0, "R7 machine");
        // R8: modify-privilege selects user previous level from machine
        mem.delete(); va = 64'h0000_0012_3456_7ABC; root = 44'h345;
        build(va, 3'd2, root, 2, -1);
        run(va, 3'd2, root, 2'd3, 1'b1, 2'd0, 1'b0, "R8 mprv translate/R2/R3/R4");
        // R8: modify-privilege selects machine previous level
        run(va, 3'd2, root, 2'd1, 1'b1, 2'd3, 1'b0, "R8 mprv bypass");
        // R9: unsupported scheme
        run(va, 3'd5, root, 2'd1, 1'b0, 2'd0, 1'b0, "R9 code5");
        run(va, 3'd7, root, 2'd0, 1'b0, 2'd0, 1'b0, "R9 code7");
        // R5: four-level all-pointer path
        mem.delete(); va = 64'h0000_7F12_3456_7000; root = 44'h777;
        build(va, 3'd3, root, 4, -1);
        run(va, 3'd3, root, 2'd1, 1'b0, 2'd0, 1'b0, "R5 exhaust");
        // R6: invalid entry at the first level
        mem.delete(); build(va, 3'd2, root, 2, 0);
        run(va, 3'd2, root, 2'd1, 1'b0, 2'd0, 1'b0, "R6 invalid first");
        // R4: top-level superpage in the three-level scheme
        mem.delete(); va = 64'h0000_0055_ABCD_E123; build(va, 3'd2, root, 0, -1);
        run(va, 3'd2, root, 2'd0, 1'b0, 2'd0, 1'b0, "R4 giga");
        // R1: two-level superpage and full walk, junk in upper data bits
        mem.delete(); va = 64'hFFFF_0000_8765_4321; build(va, 3'd1, root, 0, -1);
        run(va, 3'd1, root, 2'd1, 1'b0, 2'd0, 1'b0, "R1 mega");
        mem.delete(); build(va, 3'd1, root, 1, -1);
        run(va, 3'd1, root, 2'd1, 1'b0, 2'd0, 1'b0, "R1 two-level/R3");
        // R11: request held valid during a walk
        mem.delete(); va = 64'h0000_1234_5678_9ABC; build(va, 3'd3, root, 3, -1);
        run(va, 3'd3, root, 2'd0, 1'b0, 2'd0, 1'b1, "R11 distract");

        for (int t = 0; t < 200; t++) begin
            int r, lv, w, sz, leaf_l, bad_l;
            logic [2:0] m;
            logic [1:0] cur;
            r = $urandom_range(0, 9);
            if (r == 0) m = 3'd0;
            else if (r == 1) m = 3'($urandom_range(4, 7));
            else m = 3'($urandom_range(1, 3));
            cur = ($urandom_range(0, 7) == 0) ? 2'd3 : 2'($urandom_range(0, 1));
            va = {$urandom, $urandom};
            root = 44'($urandom_range(1, 32'hF_FFFF));
            mem.delete();
            if (m >= 3'd1 && m <= 3'd3) begin
                geo(m, lv, w, sz);
                leaf_l = $urandom_range(0, lv);
                bad_l  = ($urandom_range(0, 7) == 0) ? $urandom_range(0, lv - 1) : -1;
                build(va, m, root, leaf_l, bad_l);
            end
            run(va, m, root, cur, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                ($urandom_range(0, 3) == 0), "R1/R2/R3/R4/R5/R6 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule